// File: doc/BRIEF.md
# ADC Dither and Averaging Controller

This block is the digital back end of a 12-bit successive-approximation converter sampling at a fixed rate. It drives a sawtooth dither offset code toward an external dither DAC. It takes each returned conversion and removes the dither code that was applied to it. It then accumulates a power-of-two number of corrected samples into one averaged 12-bit result, which it presents with a one-cycle valid pulse.

The sawtooth advances by one level on every sample strobe and wraps after the programmed number of levels. Averaging windows are always a whole multiple of the sawtooth period, so every window sees every dither level equally often and the dither cancels out of the average. Configuration is taken only between windows. A setting whose averaging count is smaller than the level count is flagged and then run with the averaging count raised to match.

Top module: `adc_dither_avg`

## Requirements
- R1: While reset is asserted and right after release, dither_code_o, result_o, result_valid_o and cfg_error_o are all 0.
- R2: The dither code applied to sample k of a window (k counted from 0) is (k mod L) times S, where L = 2^cfg_lvl_i levels and S = cfg_step_i LSB. The code is visible on dither_code_o in the cycle the strobe is raised and returns to 0 at every window start.
- R3: A step code of 0 keeps dither_code_o at 0, and the result is then the plain rounded mean of the raw samples.
- R4: dither_code_o never exceeds 60 LSB for any input code, which keeps it within the 64 LSB limit.
- R5: Each sample contributes raw minus its dither code, saturated to 0 when negative and never above 4095.
- R6: After N = 2^cfg_avg_i accepted strobes, result_valid_o is high for exactly the one cycle after the edge that takes the Nth sample, and low at all other times.
- R7: result_o = floor((sum + N/2) / N), with no rounding term when N = 1.
- R8: When the averaging code is smaller than the level code, cfg_error_o is 1 and windows use N = L samples.
- R9: Step codes above 4, level codes above 4 and averaging codes above 6 are clamped to 4, 4 and 6 respectively, and they raise cfg_error_o.
- R10: Configuration inputs are taken only on an edge where no window is in progress and no strobe arrives, or on the edge that completes a window. Changes made in the middle of a window do not alter that window.
- R11: result_o holds the last averaged value between valid pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| smp_strobe_i | input | 1 | One-cycle pulse: a conversion result is present |
| smp_raw_i | input | 12 | Raw conversion result |
| cfg_step_i | input | 3 | Dither step in LSB (0 to 4) |
| cfg_lvl_i | input | 3 | log2 of the number of dither levels (0 to 4) |
| cfg_avg_i | input | 3 | log2 of the averaging count (0 to 6) |
| dither_code_o | output | 7 | Dither offset applied to the next conversion |
| cfg_error_o | output | 1 | Active configuration was illegal and has been adjusted |
| result_o | output | 12 | Averaged, dither-corrected result |
| result_valid_o | output | 1 | One-cycle pulse when result_o is updated |

## Verification
The bench focuses on samples whose raw value is smaller than the dither applied to them. A design that wraps instead of saturating would return results near full scale for inputs near zero. It also exercises averaging codes below the level code and out-of-range codes. A design without the legality fix would emit results in the middle of a sawtooth period, leaving a dither bias, or would drive more than 60 LSB of dither. Configuration is changed in the middle of windows and during back-to-back strobes. A block that applied new settings at once would average a mixed window of the wrong length. The rounding cases with sums ending in exactly one half catch a missing or misplaced half-LSB term.

// File: rtl/adc_dav_pkg.sv
package adc_dav_pkg;
  localparam int CFG_W = 3;

  typedef struct packed {
    logic [CFG_W-1:0] step;
    logic [CFG_W-1:0] lvl;
    logic [CFG_W-1:0] avg;
  } dav_cfg_t;
endpackage

// File: rtl/dav_cfg_guard.sv
module dav_cfg_guard
  import adc_dav_pkg::*;
#(
  parameter int STEP_MAX     = 4,
  parameter int LVL_LOG2_MAX = 4,
  parameter int AVG_LOG2_MAX = 6
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     load_i,
  input  dav_cfg_t req_i,
  output dav_cfg_t act_o,
  output logic     err_o
);
  localparam logic [CFG_W-1:0] STEP_CAP = CFG_W'(STEP_MAX);
  localparam logic [CFG_W-1:0] LVL_CAP  = CFG_W'(LVL_LOG2_MAX);
  localparam logic [CFG_W-1:0] AVG_CAP  = CFG_W'(AVG_LOG2_MAX);

  dav_cfg_t clip;
  dav_cfg_t act_q, act_d;
  logic     err_q, err_d;
  logic     over_step, over_lvl, over_avg, short_avg;

  // Clamp codes and lift the averaging count to cover every level.
  always_comb begin
    over_step = (req_i.step > STEP_CAP);
    over_lvl  = (req_i.lvl  > LVL_CAP);
    over_avg  = (req_i.avg  > AVG_CAP);
    clip.step = over_step ? STEP_CAP : req_i.step;
    clip.lvl  = over_lvl  ? LVL_CAP  : req_i.lvl;
    clip.avg  = over_avg  ? AVG_CAP  : req_i.avg;
    short_avg = (clip.avg < clip.lvl);
    if (short_avg) clip.avg = clip.lvl;
  end

  always_comb begin
    act_d = act_q;
    err_d = err_q;
    if (load_i) begin
      act_d = clip;
      err_d = over_step | over_lvl | over_avg | short_avg;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q <= '0;
      err_q <= 1'b0;
    end else begin
      act_q <= act_d;
      err_q <= err_d;
    end
  end

  assign act_o = act_q;
  assign err_o = err_q;

  // R8: every active window spans at least one full sawtooth period
  p_avg_covers_levels_r8: assert property (@(posedge clk) disable iff (!rst_n)
    act_q.avg >= act_q.lvl)
    else $error("active averaging code below level code");

  // R9: active codes always lie in the legal range
  p_codes_in_range_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (act_q.step <= STEP_CAP) && (act_q.lvl <= LVL_CAP) && (act_q.avg <= AVG_CAP))
    else $error("active configuration out of range");
endmodule

// File: rtl/dav_sawtooth.sv
module dav_sawtooth #(
  parameter int LVL_W    = 4,
  parameter int STEP_W   = 3,
  parameter int LOG2_W   = 3,
  parameter int DITHER_W = LVL_W + STEP_W,
  parameter int DITHER_LIMIT = 64
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                adv_i,
  input  logic                clr_i,
  input  logic [LOG2_W-1:0]   lvl_log2_i,
  input  logic [STEP_W-1:0]   step_i,
  output logic [LVL_W-1:0]    level_o,
  output logic [DITHER_W-1:0] dither_o
);
  logic [LVL_W:0]              span, span_m1;
  logic [LVL_W-1:0]            wrap_mask;
  logic [LVL_W-1:0]            level_q, level_d;
  logic [LVL_W+STEP_W-1:0]     prod;

  always_comb begin
    span      = (LVL_W+1)'(1) << lvl_log2_i;
    span_m1   = span - (LVL_W+1)'(1);
    wrap_mask = span_m1[LVL_W-1:0];
  end

  always_comb begin
    level_d = level_q;
    if (clr_i)      level_d = '0;
    else if (adv_i) level_d = (level_q + 1'b1) & wrap_mask;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) level_q <= '0;
    else        level_q <= level_d;
  end

  always_comb begin
    prod = {{STEP_W{1'b0}}, level_q} * {{LVL_W{1'b0}}, step_i};
  end

  assign dither_o = DITHER_W'(prod);
  assign level_o  = level_q;

  // R4: dither magnitude stays inside the allowed span
  p_dither_cap_r4: assert property (@(posedge clk) disable iff (!rst_n)
    dither_o <= DITHER_W'(DITHER_LIMIT))
    else $error("dither code above limit");

  // R2: the level never leaves the programmed period
  p_level_in_period_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (adv_i && !clr_i) |=> (level_q <= $past(wrap_mask)))
    else $error("sawtooth level outside period");
endmodule

// File: rtl/dav_accum.sv
module dav_accum #(
  parameter int RAW_W    = 12,
  parameter int DITHER_W = 7,
  parameter int LOG2_W   = 3,
  parameter int CNT_W    = 6,
  parameter int ACC_W    = RAW_W + CNT_W
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                strobe_i,
  input  logic [RAW_W-1:0]    raw_i,
  input  logic [DITHER_W-1:0] dither_i,
  input  logic [LOG2_W-1:0]   avg_log2_i,
  output logic [CNT_W-1:0]    cnt_o,
  output logic                done_o,
  output logic [RAW_W-1:0]    result_o,
  output logic                valid_o
);
  localparam logic [ACC_W-1:0] FULL_SCALE = ACC_W'((1 << RAW_W) - 1);

  logic signed [RAW_W:0] diff_s;
  logic [RAW_W-1:0]      corr;
  logic [CNT_W:0]        span, span_m1;
  logic [CNT_W-1:0]      last_idx;
  logic [ACC_W-1:0]      sum_now, half, rounded;
  logic [ACC_W-1:0]      acc_q, acc_d;
  logic [CNT_W-1:0]      cnt_q, cnt_d;
  logic [RAW_W-1:0]      res_q, res_d;
  logic                  vld_q, vld_d;
  logic                  done;

  // Remove the applied dither, clamp at zero.
  always_comb begin
    diff_s = $signed({1'b0, raw_i}) - $signed({{(RAW_W+1-DITHER_W){1'b0}}, dither_i});
    corr   = diff_s[RAW_W] ? '0 : diff_s[RAW_W-1:0];
  end

  always_comb begin
    span     = (CNT_W+1)'(1) << avg_log2_i;
    span_m1  = span - (CNT_W+1)'(1);
    last_idx = span_m1[CNT_W-1:0];
    done     = strobe_i && (cnt_q == last_idx);
    sum_now  = acc_q + {{(ACC_W-RAW_W){1'b0}}, corr};
    half     = (avg_log2_i == '0) ? '0 : (ACC_W'(1) << (avg_log2_i - 1'b1));
    rounded  = (sum_now + half) >> avg_log2_i;
  end

  always_comb begin
    acc_d = acc_q;
    cnt_d = cnt_q;
    res_d = res_q;
    vld_d = done;
    if (strobe_i) begin
      if (done) begin
        acc_d = '0;
        cnt_d = '0;
        res_d = rounded[RAW_W-1:0];
      end else begin
        acc_d = sum_now;
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0;
      cnt_q <= '0;
      res_q <= '0;
      vld_q <= 1'b0;
    end else begin
      acc_q <= acc_d;
      cnt_q <= cnt_d;
      res_q <= res_d;
      vld_q <= vld_d;
    end
  end

  assign cnt_o    = cnt_q;
  assign done_o   = done;
  assign result_o = res_q;
  assign valid_o  = vld_q;

  // R7: rounded mean always fits the result word
  p_round_fits_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (rounded <= FULL_SCALE))
    else $error("rounded average exceeds full scale");

  // R6: a result pulse always follows an accepted sample
  p_valid_follows_sample_r6: assert property (@(posedge clk) disable iff (!rst_n)
    vld_q |-> $past(strobe_i))
    else $error("valid without preceding sample");

  // R5: accumulator bounded by full scale per held sample
  p_acc_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
    acc_q <= (ACC_W'(cnt_q) * FULL_SCALE))
    else $error("accumulator above sample bound");
endmodule

// File: rtl/adc_dither_avg.sv
module adc_dither_avg
  import adc_dav_pkg::*;
#(
  parameter int RAW_W        = 12,
  parameter int STEP_MAX     = 4,
  parameter int LVL_LOG2_MAX = 4,
  parameter int AVG_LOG2_MAX = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             smp_strobe_i,
  input  logic [RAW_W-1:0] smp_raw_i,
  input  logic [2:0]       cfg_step_i,
  input  logic [2:0]       cfg_lvl_i,
  input  logic [2:0]       cfg_avg_i,
  output logic [6:0]       dither_code_o,
  output logic             cfg_error_o,
  output logic [RAW_W-1:0] result_o,
  output logic             result_valid_o
);
  localparam int LVL_W    = LVL_LOG2_MAX;
  localparam int DITHER_W = LVL_W + CFG_W;
  localparam int CNT_W    = AVG_LOG2_MAX;
  localparam int ACC_W    = RAW_W + AVG_LOG2_MAX;

  dav_cfg_t            req, act;
  logic                cfg_load;
  logic                win_done;
  logic [CNT_W-1:0]    smp_cnt;
  logic [LVL_W-1:0]    level;
  logic [DITHER_W-1:0] dither;

  assign req = '{step: cfg_step_i, lvl: cfg_lvl_i, avg: cfg_avg_i};

  // Settings move only between windows.
  assign cfg_load = ((smp_cnt == '0) && !smp_strobe_i) || win_done;

  dav_cfg_guard #(
    .STEP_MAX    (STEP_MAX),
    .LVL_LOG2_MAX(LVL_LOG2_MAX),
    .AVG_LOG2_MAX(AVG_LOG2_MAX)
  ) u_guard (
    .clk   (clk),
    .rst_n (rst_n),
    .load_i(cfg_load),
    .req_i (req),
    .act_o (act),
    .err_o (cfg_error_o)
  );

  dav_sawtooth #(
    .LVL_W   (LVL_W),
    .STEP_W  (CFG_W),
    .LOG2_W  (CFG_W),
    .DITHER_W(DITHER_W)
  ) u_saw (
    .clk       (clk),
    .rst_n     (rst_n),
    .adv_i     (smp_strobe_i),
    .clr_i     (win_done),
    .lvl_log2_i(act.lvl),
    .step_i    (act.step),
    .level_o   (level),
    .dither_o  (dither)
  );

  dav_accum #(
    .RAW_W   (RAW_W),
    .DITHER_W(DITHER_W),
    .LOG2_W  (CFG_W),
    .CNT_W   (CNT_W),
    .ACC_W   (ACC_W)
  ) u_acc (
    .clk       (clk),
    .rst_n     (rst_n),
    .strobe_i  (smp_strobe_i),
    .raw_i     (smp_raw_i),
    .dither_i  (dither),
    .avg_log2_i(act.avg),
    .cnt_o     (smp_cnt),
    .done_o    (win_done),
    .result_o  (result_o),
    .valid_o   (result_valid_o)
  );

  assign dither_code_o = 7'(dither);

  // R2: sawtooth and window counter start together
  p_window_aligned_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_cnt == '0) |-> (level == '0))
    else $error("window boundary inside a dither period");

  // R10: active settings frozen while a window is open
  p_cfg_frozen_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ((smp_cnt != '0) && !win_done) |=> $stable(act))
    else $error("configuration changed mid-window");

  // R3: zero step gives zero dither
  p_zero_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (act.step == '0) |-> (dither_code_o == '0))
    else $error("dither with zero step");
endmodule

// File: tb/adc_dither_avg_bench.sv
`timescale 1ns/1ps
module adc_dither_avg_bench;
  logic        clk;
  logic        rst_n;
  logic        strobe;
  logic [11:0] raw;
  logic [2:0]  c_step, c_lvl, c_avg;
  logic [6:0]  dither;
  logic        err;
  logic [11:0] res;
  logic        vld;

  int nchk = 0;
  int nerr = 0;
  bit done_flag = 0;

  adc_dither_avg u_adc_dither_avg (
    .clk           (clk),
    .rst_n         (rst_n),
    .smp_strobe_i  (strobe),
    .smp_raw_i     (raw),
    .cfg_step_i    (c_step),
    .cfg_lvl_i     (c_lvl),
    .cfg_avg_i     (c_avg),
    .dither_code_o (dither),
    .cfg_error_o   (err),
    .result_o      (res),
    .result_valid_o(vld)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  int m_step = 0, m_lvls = 1, m_avg = 1;
  bit m_err = 0;
  int q[$];
  int e_dither = 0, e_res = 0;
  bit e_valid = 0;

  task automatic decode(input int s, input int l, input int a,
                        output int st, output int lv, output int av, output bit er);
    int sc, lc, ac;
    sc = (s > 4) ? 4 : s;
    lc = (l > 4) ? 4 : l;
    ac = (a > 6) ? 6 : a;
    er = (s > 4) || (l > 4) || (a > 6) || (ac < lc);
    if (ac < lc) ac = lc;
    st = sc;
    lv = 1 << lc;
    av = 1 << ac;
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_step = 0; m_lvls = 1; m_avg = 1; m_err = 0;
      q.delete();
      e_dither = 0; e_res = 0; e_valid = 0;
    end else begin
      bit ld;
      ld = (q.size() == 0) && !strobe;
      e_valid = 0;
      if (strobe) begin
        int d, v;
        d = (q.size() % m_lvls) * m_step;
        v = int'(raw) - d;
        if (v < 0) v = 0;
        if (v > 4095) v = 4095;
        q.push_back(v);
        if (q.size() == m_avg) begin
          int sum;
          sum = 0;
          foreach (q[i]) sum += q[i];
          e_res = (sum + m_avg / 2) / m_avg;
          e_valid = 1;
          q.delete();
          ld = 1;
        end
      end
      if (ld) decode(int'(c_step), int'(c_lvl), int'(c_avg), m_step, m_lvls, m_avg, m_err);
      e_dither = (q.size() % m_lvls) * m_step;
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done_flag) begin
      chk(int'(dither) == e_dither, "R2 dither code", int'(dither), e_dither);
      chk(vld == e_valid, "R6 valid pulse", int'(vld), int'(e_valid));
      chk(int'(res) == e_res, "R11 result value", int'(res), e_res);
      chk(err == m_err, "R8 config error", int'(err), int'(m_err));
      chk(int'(dither) <= 60, "R4 dither bound", int'(dither), 60);
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic send(input int v);
    @(negedge clk);
    strobe = 1'b1;
    raw = 12'(v);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      strobe = 1'b0;
    end
  endtask

  task automatic set_cfg(input int s, input int l, input int a);
    @(negedge clk);
    strobe = 1'b0;
    c_step = 3'(s); c_lvl = 3'(l); c_avg = 3'(a);
    idle(1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nerr++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    rst_n = 1'b0; strobe = 1'b0; raw = '0;
    c_step = '0; c_lvl = '0; c_avg = '0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(dither == 0 && res == 0 && vld == 0 && err == 0, "R1 reset outputs",
        int'(dither) + int'(res) + int'(vld) + int'(err), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(dither == 0 && res == 0 && vld == 0, "R1 after release",
        int'(dither) + int'(res) + int'(vld), 0);

    // R3: zero step, N = 4
    set_cfg(0, 0, 2);
    for (int k = 0; k < 4; k++) send(1000 + k);
    idle(1);
    chk(vld == 1'b1, "R3 valid", int'(vld), 1);
    chk(res == 12'd1002, "R3 plain mean", int'(res), 1002);
    chk(dither == 0, "R3 zero dither", int'(dither), 0);

    // R7 rounding: N = 2, sum 21
    set_cfg(0, 0, 1);
    send(10); send(11); idle(1);
    chk(res == 12'd11, "R7 round half up", int'(res), (21 + 1) / 2);
    idle(1);
    chk(vld == 1'b0 && res == 12'd11, "R11 hold after pulse", int'(res), 11);

    // R5 saturation: step 4, 4 levels, raw 5
    set_cfg(4, 2, 2);
    for (int k = 0; k < 4; k++) send(5);
    idle(1);
    chk(res == 12'd2, "R5 clamp at zero", int'(res), (5 + 1 + 0 + 0 + 2) / 4);

    // R2 sawtooth: step 3, 4 levels, N = 8
    set_cfg(3, 2, 3);
    for (int k = 0; k < 8; k++) begin
      @(negedge clk);
      chk(int'(dither) == (k % 4) * 3, "R2 sawtooth level", int'(dither), (k % 4) * 3);
      strobe = 1'b1;
      raw = 12'd3000;
    end
    idle(1);
    chk(res == 12'd2996, "R2 dither cancels", int'(res), (8 * 3000 - 2 * 18 + 4) / 8);

    // R8: averaging code below level code
    set_cfg(1, 4, 1);
    chk(err == 1'b1, "R8 error flag", int'(err), 1);
    send(2000); send(2000); idle(1);
    chk(vld == 1'b0, "R8 no early result", int'(vld), 0);
    for (int k = 2; k < 16; k++) send(2000);
    idle(1);
    chk(vld == 1'b1, "R8 window of 16", int'(vld), 1);
    chk(res == 12'd1993, "R8 result", int'(res), (16 * 2000 - 120 + 8) / 16);

    // R9 clamp of out-of-range codes, R4 max dither
    set_cfg(7, 7, 7);
    chk(err == 1'b1, "R9 error flag", int'(err), 1);
    for (int k = 0; k < 15; k++) send(4095);
    @(negedge clk);
    chk(int'(dither) == 60, "R4 peak dither", int'(dither), 60);
    strobe = 1'b1; raw = 12'd4095;
    for (int k = 16; k < 64; k++) send(4095);
    idle(1);
    chk(int'(res) == (4 * (16 * 4095 - 4 * 120) + 32) / 64, "R9 clamped window",
        int'(res), (4 * (16 * 4095 - 4 * 120) + 32) / 64);

    // R10: change in the middle of a window
    set_cfg(0, 0, 2);
    chk(err == 1'b0, "R10 legal config", int'(err), 0);
    send(100); send(100);
    @(negedge clk);
    strobe = 1'b0;
    c_step = 3'd0; c_lvl = 3'd0; c_avg = 3'd0;
    send(300); send(300); idle(1);
    chk(vld == 1'b1 && res == 12'd200, "R10 old window kept", int'(res), (800 + 2) / 4);
    send(77); idle(1);
    chk(vld == 1'b1 && res == 12'd77, "R10 new setting applied", int'(res), 77);

    // Mixed traffic checked by the model every cycle
    for (int i = 0; i < 600; i++) begin
      if ($urandom_range(0, 19) == 0) begin
        c_step = 3'($urandom_range(0, 7));
        c_lvl  = 3'($urandom_range(0, 7));
        c_avg  = 3'($urandom_range(0, 7));
      end
      send(($urandom_range(0, 3) == 0) ? $urandom_range(0, 40) : $urandom_range(0, 4095));
      if ($urandom_range(0, 2) == 0) idle($urandom_range(1, 3));
    end
    idle(80);

    done_flag = 1;
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule